// File: doc/BRIEF.md
# PTP Fine-Adjust Time Counter

This block keeps a time-of-day value as a 32-bit seconds count and a nanoseconds count, and it is clocked by the precision-time reference clock. It has two advance modes. In fine mode, a programmable addend is summed into a 32-bit phase accumulator on every cycle. The time moves forward by a programmable nanosecond increment only on cycles where that sum carries out of the accumulator. In coarse mode, the time moves forward by the increment on every cycle.

The fine mode is intended to run with the increment set to two reference-clock periods and the addend near mid-range (2^31). At that setting the accumulator carries on every second cycle. Software then trims the clock rate by nudging the addend up or down. For example, a 25 MHz clock uses an increment of 80 ns and a 200 MHz clock uses 10 ns, both with an addend of 2^31. An addend of zero never produces a carry, so the time stops. This is the failure mode seen when a computed addend of 2^32 is truncated to 32 bits.

Configuration is done through a single write strobe with a 2-bit selector. The same strobe also sets the time directly.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset, both time outputs are zero. Fine mode is selected, the addend is 2^31 and the increment is 20 ns, so the time advances by 20 ns on every second cycle.
- R2: In fine mode, the addend is summed into a 32-bit accumulator on every cycle. The time advances by the increment exactly on the cycles where that sum carries out. After a time load followed by N cycles, the time therefore has advanced by increment × floor(N × addend / 2^32).
- R3: In coarse mode (mode bit 0 written as 0), the time advances by the increment on every cycle.
- R4: With an addend of zero in fine mode, the accumulator never carries and the time holds its value for any number of cycles.
- R5: The nanoseconds output stays below 1,000,000,000. When an advance reaches or passes that value, the nanoseconds output keeps the remainder and the seconds output gains one, including for increments that do not divide 10^9. The seconds output wraps from 2^32-1 to 0.
- R6: A write with selector 3 sets seconds to wr_data and nanoseconds to wr_ns on the clock edge that samples it, and clears the accumulator. In that cycle the load takes precedence over any advance.
- R7: The selector codes are: 0 = addend (wr_data), 1 = increment (wr_data bits 7:0, higher bits ignored), 2 = mode (wr_data bit 0, 1 = fine, 0 = coarse). A write is stored on the edge that samples it and governs the advance from the following edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 2 | Write target: 0 addend, 1 increment, 2 mode, 3 time load |
| wr_data | input | 32 | Write value; the seconds value for a time load |
| wr_ns | input | 30 | Nanoseconds value for a time load (below 10^9) |
| tod_sec | output | 32 | Current seconds |
| tod_ns | output | 30 | Current nanoseconds |

## Verification
A configuration write lands on its sampling edge and first affects the time on the next edge. A time load shows on the outputs immediately after its own edge. After a load, every later edge contributes at most one advance. The bench therefore performs all configuration writes before the load. After the load, it waits a counted N edges and samples on the falling edge that follows. The expected value comes from closed-form arithmetic in N, the addend and the increment: floor(N × addend / 2^32) steps in fine mode and N steps in coarse mode, with the nanosecond sum folded into seconds. Sweeps cover several addends and increments, runs that start just below a nanosecond wrap, and a zero-length run that isolates the load edge itself.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;

  localparam int SEC_W  = 32;
  localparam int NS_W   = 30;
  localparam int DATA_W = 32;

  localparam logic [NS_W:0] NS_LIMIT = 31'd1_000_000_000;

  typedef enum logic [1:0] {
    SEL_ADDEND = 2'd0,
    SEL_INCR   = 2'd1,
    SEL_MODE   = 2'd2,
    SEL_LOAD   = 2'd3
  } wr_sel_e;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
  } tod_t;

  // Add an increment (below the nanosecond limit) to a time value,
  // folding an overflowing nanosecond sum into seconds.
  function automatic tod_t tod_advance(input tod_t t, input logic [NS_W-1:0] inc);
    tod_t          r;
    logic [NS_W:0] sum;
    sum = {1'b0, t.ns} + {1'b0, inc};
    if (sum >= NS_LIMIT) begin
      r.ns  = NS_W'(sum - NS_LIMIT);
      r.sec = t.sec + 1'b1;
    end else begin
      r.ns  = sum[NS_W-1:0];
      r.sec = t.sec;
    end
    return r;
  endfunction

endpackage

// File: rtl/ptp_tc_cfg.sv
module ptp_tc_cfg
  import ptp_tc_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int INC_W = 8,
  parameter logic [ACC_W-1:0] DEF_ADDEND = ACC_W'(1) << (ACC_W - 1),
  parameter logic [INC_W-1:0] DEF_INCR   = INC_W'(20)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ACC_W-1:0]  addend,
  output logic [INC_W-1:0]  incr,
  output logic              fine_mode,
  output logic              load_req
);

  wr_sel_e sel;
  assign sel      = wr_sel_e'(wr_sel);
  assign load_req = wr_en && (sel == SEL_LOAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addend    <= DEF_ADDEND;
      incr      <= DEF_INCR;
      fine_mode <= 1'b1;
    end else if (wr_en) begin
      case (sel)
        SEL_ADDEND: addend    <= wr_data[ACC_W-1:0];
        SEL_INCR:   incr      <= wr_data[INC_W-1:0];
        SEL_MODE:   fine_mode <= wr_data[0];
        default:    ;
      endcase
    end
  end

  // R7
  incr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_INCR) |=> $stable(incr));

endmodule

// File: rtl/ptp_tc_acc.sv
module ptp_tc_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             fine_mode,
  input  logic [ACC_W-1:0] addend,
  output logic             carry
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum   = {1'b0, acc_q} + {1'b0, addend};
  assign carry = fine_mode && sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      acc_q <= '0;
    else if (fine_mode)
      acc_q <= sum[ACC_W-1:0];
  end

  // R4
  zero_addend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && addend == '0) |=> $stable(acc_q));

  // R6
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> acc_q == '0);

endmodule

// File: rtl/ptp_tc_tod.sv
module ptp_tc_tod
  import ptp_tc_pkg::*;
#(
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEC_W-1:0] load_sec,
  input  logic [NS_W-1:0]  load_ns,
  input  logic             step,
  input  logic [INC_W-1:0] incr,
  output logic [SEC_W-1:0] tod_sec,
  output logic [NS_W-1:0]  tod_ns
);

  tod_t cur, nxt;
  logic [NS_W-1:0] incr_ext;

  assign incr_ext = NS_W'(incr);
  assign nxt      = tod_advance(cur, incr_ext);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cur <= '0;
    else if (load)
      cur <= '{sec: load_sec, ns: load_ns};
    else if (step)
      cur <= nxt;
  end

  assign tod_sec = cur.sec;
  assign tod_ns  = cur.ns;

  // R5
  ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> tod_ns < NS_W'(NS_LIMIT));

  // R5
  sec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && ({1'b0, tod_ns} + {1'b0, incr_ext}) >= NS_LIMIT)
      |=> tod_sec == $past(tod_sec) + 1'b1);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> ($stable(tod_sec) && $stable(tod_ns)));

endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_tc_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int INC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NS_W-1:0]   wr_ns,
  output logic [SEC_W-1:0]  tod_sec,
  output logic [NS_W-1:0]   tod_ns
);

  logic [ACC_W-1:0] addend;
  logic [INC_W-1:0] incr;
  logic             fine_mode;
  logic             load_req;
  logic             acc_carry;
  logic             time_step;

  ptp_tc_cfg #(.ACC_W(ACC_W), .INC_W(INC_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .addend    (addend),
    .incr      (incr),
    .fine_mode (fine_mode),
    .load_req  (load_req)
  );

  ptp_tc_acc #(.ACC_W(ACC_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (load_req),
    .fine_mode (fine_mode),
    .addend    (addend),
    .carry     (acc_carry)
  );

  assign time_step = fine_mode ? acc_carry : 1'b1;

  ptp_tc_tod #(.INC_W(INC_W)) u_tod (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_req),
    .load_sec (wr_data[SEC_W-1:0]),
    .load_ns  (wr_ns),
    .step     (time_step),
    .incr     (incr),
    .tod_sec  (tod_sec),
    .tod_ns   (tod_ns)
  );

  // R6
  load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> (tod_sec == $past(wr_data[SEC_W-1:0]) && tod_ns == $past(wr_ns)));

  // R3
  coarse_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fine_mode && !load_req && incr != '0) |=> !($stable(tod_sec) && $stable(tod_ns)));

endmodule

// File: tb/tb_ptp_time_counter.sv
module tb_ptp_time_counter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [29:0] wr_ns = '0;
  logic [31:0] tod_sec;
  logic [29:0] tod_ns;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ptp_time_counter dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .wr_ns(wr_ns), .tod_sec(tod_sec), .tod_ns(tod_ns)
  );

  task automatic check_time(input string req, input longint unsigned es, input longint unsigned en);
    checks++;
    if (tod_sec !== es[31:0] || tod_ns !== en[29:0]) begin
      errors++;
      $display("FAIL %s: got sec=%0d ns=%0d, expected sec=%0d ns=%0d",
               req, tod_sec, tod_ns, es[31:0], en[29:0]);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d, input logic [29:0] n);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; wr_ns = n;
  endtask

  // Configure, load, run n_cyc edges, compare with closed-form arithmetic.
  task automatic run_case(input string req, input bit fine, input logic [31:0] add,
                          input logic [31:0] inc_word, input logic [31:0] s0,
                          input logic [29:0] n0, input int n_cyc);
    longint unsigned steps, total, inc;
    inc = longint'(inc_word[7:0]);
    wr(2'd0, add, '0);
    wr(2'd1, inc_word, '0);
    wr(2'd2, {31'd0, fine}, '0);
    wr(2'd3, s0, n0);
    @(negedge clk);
    wr_en = 1'b0;
    repeat (n_cyc) @(negedge clk);
    steps = fine ? ((longint'(n_cyc) * longint'(add)) >> 32) : longint'(n_cyc);
    total = longint'(n0) + steps * inc;
    check_time(req, (longint'(s0) + total / 64'd1000000000) & 64'hFFFF_FFFF,
               total % 64'd1000000000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check_time("R1 reset", 0, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    // R1: defaults give 20 ns every second cycle
    check_time("R1 defaults", 0, 100);

    run_case("R2 mid addend 10ns", 1'b1, 32'h8000_0000, 32'd10, 32'd5, 30'd0, 20);
    run_case("R2 mid addend 80ns", 1'b1, 32'h8000_0000, 32'd80, 32'd0, 30'd1000, 7);
    // R6: previous run leaves a nonzero accumulator that the load must clear
    run_case("R6 acc clear", 1'b1, 32'hC000_0000, 32'd3, 32'd9, 30'd0, 5);
    run_case("R6 load edge", 1'b1, 32'hFFFF_FFFF, 32'd200, 32'd77, 30'd123456, 0);
    run_case("R4 zero addend", 1'b1, 32'h0000_0000, 32'd80, 32'd3, 30'd500, 50);
    run_case("R3 coarse", 1'b0, 32'h0000_0000, 32'd7, 32'd1, 30'd0, 9);
    run_case("R7 incr low bits", 1'b0, 32'h8000_0000, 32'h0000_0105, 32'd2, 30'd0, 6);
    run_case("R5 wrap coarse", 1'b0, 32'h8000_0000, 32'd7, 32'd41, 30'd999_999_990, 3);
    run_case("R5 wrap fine", 1'b1, 32'h8000_0000, 32'd13, 32'd8, 30'd999_999_999, 200);
    run_case("R5 sec wrap", 1'b0, 32'h8000_0000, 32'd1, 32'hFFFF_FFFF, 30'd999_999_999, 1);

    // R2 sweep over addends and increments
    for (int a = 0; a < 4; a++) begin
      for (int i = 1; i < 256; i += 51) begin
        logic [31:0] av;
        case (a)
          0: av = 32'h4000_0000;
          1: av = 32'h5555_5555;
          2: av = 32'hFFFF_FFFF;
          default: av = 32'h0000_1000;
        endcase
        run_case("R2 sweep", 1'b1, av, 32'(i), 32'd100, 30'd999_999_000, 40);
      end
    end
    // R5 sweep: coarse runs across the nanosecond wrap
    for (int i = 1; i < 256; i += 17)
      run_case("R5 sweep", 1'b0, 32'h8000_0000, 32'(i), 32'd7, 30'd999_999_980, 4);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule